// File: doc/BRIEF.md
# Two-Master Mailbox and Scratch Register Bank

This block is a small byte-wide register file shared by two bus masters. One is a remote host that reaches the chip through a card interface. The other is the local processor. Each master has its own address, write-enable, read-enable and data lines. Both ports are served in the same clock cycle without arbitration, because every register has exactly one side that may write it.

The bank holds three groups of four registers.

- Scratch bytes owned by the host: the host writes them and the local side reads them.
- Scratch bytes owned by the local side: the local side writes them and the host reads them.
- Mailboxes: the local side writes them, and each write can raise an interrupt toward the host.

Each mailbox interrupt has an enable bit, supplied on an input, that decides whether a local write raises it. A host read of that mailbox clears it.

A control byte carries two interface-reset status flags, which the local side maintains. It also carries a self-clearing bit that lets the host fire a fixed-length reset pulse at an attached peripheral.

Top module: `dual_port_mailbox_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads 00h from both sides, `host_irq` is 0 and `periph_rst` is 0.
- R2: The address map uses a stride of 4, and a read returns a register only at its exact address.
  - Host-owned scratch bytes are at 0x128 + 4·i.
  - Mailboxes are at 0x13C + 4·i.
  - Local-owned scratch bytes are at 0x150 + 4·i.
  - The control byte is at 0x164.
  - Read data follows the address combinationally in the same cycle.
- R3: The host-owned scratch bytes (0x128–0x134) are written by the host and read by both sides. A local write to them has no effect.
- R4: The mailboxes and the local-owned scratch bytes are written by the local side and read by both sides. A host write to them has no effect.
- R5: A local write to mailbox i sets interrupt i pending only when `mbx_irq_en[i]` is 1. With the enable at 0, the write stores the data and leaves interrupt i unchanged. `host_irq` is the OR of the four pending bits.
- R6: A host read (`hst_rd_en` high) of mailbox i clears pending bit i and no other. If a local write that sets bit i and a host read of mailbox i happen in the same cycle, the bit ends up set.
- R7: In the control byte, bit 2 (host-side interface reset flag) and bit 1 (function-side reset flag) are written only by the local side and read by both sides. Bit 0 is read-only for the local side. Bits 7..3 always read 0.
- R8: A host write to 0x164 with data bit 0 set does two things:
  - `periph_rst` goes high for exactly 4 cycles, starting the cycle after the write.
  - Control bit 0 reads 1 for exactly the cycles in which `periph_rst` is high.
  A host write of 1 while the pulse is running has no effect, and a host write of 0 has no effect.
- R9: A read returns 00h in three cases: the address is unmapped, the address is not aligned to 4, or the port's read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_addr | input | 9 | Local port byte address |
| loc_wr_en | input | 1 | Local write strobe |
| loc_rd_en | input | 1 | Local read enable |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data (combinational) |
| hst_addr | input | 9 | Host port byte address |
| hst_wr_en | input | 1 | Host write strobe |
| hst_rd_en | input | 1 | Host read enable; a mailbox read clears its interrupt |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data (combinational) |
| mbx_irq_en | input | 4 | Per-mailbox interrupt enable |
| host_irq | output | 1 | OR of the pending mailbox interrupts |
| periph_rst | output | 1 | Reset pulse to the attached peripheral |

## Verification
The hardest case to reach is the same-cycle collision on one mailbox. It needs a local write and a host read aimed at the same address on the same edge, with that mailbox's interrupt already pending. The bench drives both ports from one task at a single falling edge to create it.

A second hard case is a combination of pending bits where the OR output hides which bit is still pending. To expose it, the bench sweeps all sixteen enable masks. For each mask it writes every mailbox, then clears the mailboxes one at a time. After each clear it compares `host_irq` against whether any enabled mailbox is still uncleared.

// File: rtl/mbx_bank_pkg.sv
// Package: address map constants shared by the bank, its submodules and checker.
// Assumes byte addresses with registers placed on a 4-byte stride.
package mbx_bank_pkg;
    localparam int unsigned REG_STRIDE   = 4;
    localparam int unsigned HOWN_SCR_BASE = 'h128;
    localparam int unsigned MBX_BASE      = 'h13C;
    localparam int unsigned LOWN_SCR_BASE = 'h150;
    localparam int unsigned CTL_ADDR      = 'h164;
endpackage

// File: rtl/mbx_reg_group.sv
// Module: a group of N byte registers written by one port and read by two.
// Assumes the writer has sole write access; read data is zero when the
// address matches no register of the group.
module mbx_reg_group #(
    parameter int unsigned N_REG  = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned BASE   = 0,
    parameter int unsigned STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_data,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_data
);
    logic [DATA_W-1:0] regs [N_REG];
    logic [N_REG-1:0]  a_hit;
    logic [N_REG-1:0]  b_hit;

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        localparam int unsigned OFF = BASE + STRIDE * i;
        assign a_hit[i] = (a_addr == ADDR_W'(OFF));
        assign b_hit[i] = (b_addr == ADDR_W'(OFF));

        // Store one byte when the owning port writes its exact address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(OFF)))
                regs[i] <= wr_data;
        end
    end

    // Select the addressed byte for both read ports (zero on no match).
    always_comb begin
        a_data = '0;
        b_data = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (a_hit[i]) a_data = a_data | regs[i];
            if (b_hit[i]) b_data = b_data | regs[i];
        end
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
// Module: per-mailbox pending interrupt bits toward the host.
// Assumes set comes from a local write with enable, clear from a host read;
// set has priority when both hit the same mailbox in one cycle.
module mbx_irq_ctrl #(
    parameter int unsigned N_MBX  = 4,
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned BASE   = 0,
    parameter int unsigned STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [N_MBX-1:0]  irq_en,
    input  logic              clr_rd_en,
    input  logic [ADDR_W-1:0] clr_addr,
    output logic              irq
);
    logic [N_MBX-1:0] pend;

    for (genvar i = 0; i < N_MBX; i++) begin : g_pend
        localparam int unsigned OFF = BASE + STRIDE * i;
        logic set_i;
        logic clr_i;
        assign set_i = set_wr_en && (set_addr == ADDR_W'(OFF)) && irq_en[i];
        assign clr_i = clr_rd_en && (clr_addr == ADDR_W'(OFF));

        // Track pending state: set wins over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n)     pend[i] <= 1'b0;
            else if (set_i) pend[i] <= 1'b1;
            else if (clr_i) pend[i] <= 1'b0;
        end
    end

    assign irq = |pend;
endmodule

// File: rtl/mbx_periph_reset.sv
// Module: fixed-length reset pulse generator for the attached peripheral.
// Assumes a trigger while the pulse runs is dropped (no retrigger).
module mbx_periph_reset #(
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
    logic [CNT_W-1:0] remain;

    // Load the pulse length on an idle trigger, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (trig && (remain == '0))
            remain <= CNT_W'(PULSE_CYC);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);
endmodule

// File: rtl/dual_port_mailbox_bank.sv
// Module: top of the two-master mailbox/scratch bank.
// Assumes each register has exactly one writing side, so both ports act in
// the same cycle without arbitration; reads are combinational and gated by
// each port's read enable.
module dual_port_mailbox_bank
    import mbx_bank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned N_REG     = 4,
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              loc_wr_en,
    input  logic              loc_rd_en,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr_en,
    input  logic              hst_rd_en,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic [N_REG-1:0]  mbx_irq_en,
    output logic              host_irq,
    output logic              periph_rst
);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

    logic [DATA_W-1:0] hown_h, hown_l, mbx_h, mbx_l, lown_h, lown_l;
    logic [DATA_W-1:0] ctl_byte;
    logic              flag_host_rst, flag_func_rst;
    logic              pulse_trig;

    mbx_reg_group #(.N_REG(N_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                    .BASE(HOWN_SCR_BASE), .STRIDE(REG_STRIDE)) u_hown_scr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(hst_wr_en), .wr_addr(hst_addr), .wr_data(hst_wdata),
        .a_addr(hst_addr), .a_data(hown_h),
        .b_addr(loc_addr), .b_data(hown_l));

    mbx_reg_group #(.N_REG(N_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                    .BASE(MBX_BASE), .STRIDE(REG_STRIDE)) u_mbx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(loc_wr_en), .wr_addr(loc_addr), .wr_data(loc_wdata),
        .a_addr(hst_addr), .a_data(mbx_h),
        .b_addr(loc_addr), .b_data(mbx_l));

    mbx_reg_group #(.N_REG(N_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                    .BASE(LOWN_SCR_BASE), .STRIDE(REG_STRIDE)) u_lown_scr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(loc_wr_en), .wr_addr(loc_addr), .wr_data(loc_wdata),
        .a_addr(hst_addr), .a_data(lown_h),
        .b_addr(loc_addr), .b_data(lown_l));

    mbx_irq_ctrl #(.N_MBX(N_REG), .ADDR_W(ADDR_W),
                   .BASE(MBX_BASE), .STRIDE(REG_STRIDE)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_wr_en(loc_wr_en), .set_addr(loc_addr), .irq_en(mbx_irq_en),
        .clr_rd_en(hst_rd_en), .clr_addr(hst_addr),
        .irq(host_irq));

    assign pulse_trig = hst_wr_en && (hst_addr == CTL_A) && hst_wdata[0];

    mbx_periph_reset #(.PULSE_CYC(PULSE_CYC)) u_prst (
        .clk(clk), .rst_n(rst_n), .trig(pulse_trig), .active(periph_rst));

    // Interface reset status flags, written only by the local side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_host_rst <= 1'b0;
            flag_func_rst <= 1'b0;
        end else if (loc_wr_en && (loc_addr == CTL_A)) begin
            flag_host_rst <= loc_wdata[2];
            flag_func_rst <= loc_wdata[1];
        end
    end

    assign ctl_byte = DATA_W'({flag_host_rst, flag_func_rst, periph_rst});

    // Merge group outputs and the control byte into each port's read data.
    always_comb begin
        loc_rdata = '0;
        hst_rdata = '0;
        if (loc_rd_en)
            loc_rdata = hown_l | mbx_l | lown_l |
                        ((loc_addr == CTL_A) ? ctl_byte : '0);
        if (hst_rd_en)
            hst_rdata = hown_h | mbx_h | lown_h |
                        ((hst_addr == CTL_A) ? ctl_byte : '0);
    end
endmodule

// File: rtl/mbx_bank_checker.sv
// Module: assertion checker bound to the bank top; observes ports only.
module mbx_bank_checker
    import mbx_bank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned N_REG     = 4,
    parameter int unsigned PULSE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              loc_wr_en,
    input logic              loc_rd_en,
    input logic [DATA_W-1:0] loc_rdata,
    input logic [ADDR_W-1:0] hst_addr,
    input logic              hst_wr_en,
    input logic [DATA_W-1:0] hst_wdata,
    input logic [N_REG-1:0]  mbx_irq_en,
    input logic              host_irq,
    input logic              periph_rst
);
    localparam int unsigned RUN_W = $clog2(PULSE_CYC + 2);
    logic [RUN_W-1:0] hi_run;

    // Count consecutive high cycles of the peripheral reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_run <= '0;
        else if (!periph_rst)       hi_run <= '0;
        else if (hi_run != '1)      hi_run <= hi_run + 1'b1;
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr_en && loc_addr == ADDR_W'(MBX_BASE) && mbx_irq_en[0]) |=> host_irq); // R5
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_irq && !loc_wr_en) |=> !host_irq); // R5
    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && hst_addr == ADDR_W'(CTL_ADDR) && hst_wdata[0] && !periph_rst) |=> periph_rst); // R8
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst |-> (hi_run < RUN_W'(PULSE_CYC))); // R8
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_rst) |-> (hi_run == RUN_W'(PULSE_CYC))); // R8
    AST_CTL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr == ADDR_W'(CTL_ADDR)) |-> (loc_rdata[DATA_W-1:3] == '0)); // R7
    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_rd_en |-> (loc_rdata == '0)); // R9
    AST_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr[1:0] != 2'b00) |-> (loc_rdata == '0)); // R9
endmodule

bind dual_port_mailbox_bank mbx_bank_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_REG(N_REG), .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .loc_wr_en(loc_wr_en),
    .loc_rd_en(loc_rd_en), .loc_rdata(loc_rdata), .hst_addr(hst_addr),
    .hst_wr_en(hst_wr_en), .hst_wdata(hst_wdata), .mbx_irq_en(mbx_irq_en),
    .host_irq(host_irq), .periph_rst(periph_rst));

// File: tb/dual_port_mailbox_bank_bench.sv
`timescale 1ns/1ps
module dual_port_mailbox_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] loc_addr = '0, hst_addr = '0;
    logic       loc_wr_en = 1'b0, loc_rd_en = 1'b0;
    logic       hst_wr_en = 1'b0, hst_rd_en = 1'b0;
    logic [7:0] loc_wdata = '0, hst_wdata = '0;
    logic [7:0] loc_rdata, hst_rdata;
    logic [3:0] mbx_irq_en = '0;
    logic       host_irq, periph_rst;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Bench-side model of register contents.
    logic [7:0] m_hown [4];
    logic [7:0] m_mbx  [4];
    logic [7:0] m_lown [4];
    logic       m_hflag = 1'b0, m_fflag = 1'b0;

    always #2.5 clk = ~clk;

    dual_port_mailbox_bank u_dual_port_mailbox_bank (
        .clk(clk), .rst_n(rst_n),
        .loc_addr(loc_addr), .loc_wr_en(loc_wr_en), .loc_rd_en(loc_rd_en),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .hst_addr(hst_addr), .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .mbx_irq_en(mbx_irq_en), .host_irq(host_irq), .periph_rst(periph_rst));

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Expected read value for either side (both sides see the same map).
    function automatic logic [7:0] model_rd(int a);
        for (int i = 0; i < 4; i++) begin
            if (a == 'h128 + 4*i) return m_hown[i];
            if (a == 'h13C + 4*i) return m_mbx[i];
            if (a == 'h150 + 4*i) return m_lown[i];
        end
        if (a == 'h164) return {5'b0, m_hflag, m_fflag, 1'b0};
        return 8'h00;
    endfunction

    function automatic string region(int a);
        if (a >= 'h128 && a <= 'h134 && a % 4 == 0) return "R3";
        if (a >= 'h13C && a <= 'h15C && a % 4 == 0) return "R4";
        if (a == 'h164) return "R7";
        return "R9";
    endfunction

    task automatic loc_wr(int a, logic [7:0] d);
        @(negedge clk);
        loc_addr = 9'(a); loc_wdata = d; loc_wr_en = 1'b1;
        @(negedge clk);
        loc_wr_en = 1'b0;
    endtask

    task automatic hst_wr(int a, logic [7:0] d);
        @(negedge clk);
        hst_addr = 9'(a); hst_wdata = d; hst_wr_en = 1'b1;
        @(negedge clk);
        hst_wr_en = 1'b0;
    endtask

    task automatic hst_rd(int a);
        @(negedge clk);
        hst_addr = 9'(a); hst_rd_en = 1'b1;
        @(negedge clk);
        hst_rd_en = 1'b0;
    endtask

    // Read every address from both sides and compare with the model.
    task automatic sweep(string tag);
        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            loc_addr = 9'(a); hst_addr = 9'(a);
            loc_rd_en = 1'b1; hst_rd_en = 1'b1;
            #1;
            check({region(a), " R2 loc ", tag}, loc_rdata, model_rd(a));
            check({region(a), " R2 hst ", tag}, hst_rdata, model_rd(a));
        end
        @(negedge clk);
        loc_rd_en = 1'b0; hst_rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_hown[i] = '0; m_mbx[i] = '0; m_lown[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 host_irq", {7'b0, host_irq}, 8'h00);
        check("R1 periph_rst", {7'b0, periph_rst}, 8'h00);
        sweep("R1 reset");

        // R3/R4/R7: load from the owning side
        for (int i = 0; i < 4; i++) begin
            m_hown[i] = 8'hA0 + 8'(7*i);  hst_wr('h128 + 4*i, m_hown[i]);
            m_mbx[i]  = 8'h31 + 8'(5*i);  loc_wr('h13C + 4*i, m_mbx[i]);
            m_lown[i] = 8'hC3 ^ 8'(i*17); loc_wr('h150 + 4*i, m_lown[i]);
        end
        loc_wr('h164, 8'hFF); m_hflag = 1'b1; m_fflag = 1'b1;
        check("R7 local bit0 write ignored", {7'b0, periph_rst}, 8'h00);
        // writes from the read-only side must be ignored
        for (int i = 0; i < 4; i++) begin
            loc_wr('h128 + 4*i, 8'h55);
            hst_wr('h13C + 4*i, 8'h55);
            hst_wr('h150 + 4*i, 8'h55);
        end
        hst_wr('h164, 8'h00);
        check("R8 host write 0 no pulse", {7'b0, periph_rst}, 8'h00);
        check("R5 writes with enables off", {7'b0, host_irq}, 8'h00);
        sweep("loaded");

        // R9: read enable low gives zero
        @(negedge clk);
        loc_addr = 9'h128; hst_addr = 9'h150; loc_rd_en = 1'b0; hst_rd_en = 1'b0;
        #1;
        check("R9 loc rd_en low", loc_rdata, 8'h00);
        check("R9 hst rd_en low", hst_rdata, 8'h00);

        // R5/R6: sweep all enable masks, then clear one mailbox at a time
        for (int mask = 0; mask < 16; mask++) begin
            @(negedge clk); mbx_irq_en = 4'(mask);
            for (int i = 0; i < 4; i++) begin
                m_mbx[i] = 8'(mask * 16 + i); loc_wr('h13C + 4*i, m_mbx[i]);
            end
            check("R5 irq after writes", {7'b0, host_irq}, {7'b0, mask != 0});
            for (int i = 0; i < 4; i++) begin
                hst_rd('h13C + 4*i);
                check("R6 irq after clearing", {7'b0, host_irq},
                      {7'b0, ((mask >> (i + 1)) != 0)});
            end
        end

        // R6: set and clear on the same mailbox in the same cycle
        @(negedge clk); mbx_irq_en = 4'hF;
        loc_wr('h144, 8'h77); m_mbx[2] = 8'h77;
        @(negedge clk);
        loc_addr = 9'h144; loc_wdata = 8'h78; loc_wr_en = 1'b1;
        hst_addr = 9'h144; hst_rd_en = 1'b1;
        @(negedge clk);
        loc_wr_en = 1'b0; hst_rd_en = 1'b0; m_mbx[2] = 8'h78;
        check("R6 set wins collision", {7'b0, host_irq}, 8'h01);
        hst_rd('h144);
        check("R6 clear after collision", {7'b0, host_irq}, 8'h00);

        // R8: peripheral reset pulse of four cycles, bit 0 mirrors it
        hst_wr('h164, 8'h01);
        for (int k = 0; k < 4; k++) begin
            check("R8 pulse high", {7'b0, periph_rst}, 8'h01);
            loc_addr = 9'h164; loc_rd_en = 1'b1; #0.5;
            check("R8 bit0 reads 1", loc_rdata, 8'h07);
            if (k == 1) begin
                hst_addr = 9'h164; hst_wdata = 8'h01; hst_wr_en = 1'b1;
            end
            @(negedge clk);
            hst_wr_en = 1'b0;
        end
        check("R8 pulse ended", {7'b0, periph_rst}, 8'h00);
        #0.5;
        check("R8 bit0 self-cleared", loc_rdata, 8'h06);
        loc_rd_en = 1'b0;

        // R7: flags cleared by local side, host cannot set them
        loc_wr('h164, 8'h02); m_hflag = 1'b0; m_fflag = 1'b1;
        hst_wr('h164, 8'h04);
        check("R8 host write 0 in bit0", {7'b0, periph_rst}, 8'h00);
        sweep("final");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule